// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for every data beat of an SDRAM read or write burst. A start pulse, issued with a READ or WRITE command, loads the start column. It also loads the burst length code and the wrap order. From the next clock on, the block presents one column per cycle together with a valid strobe. A flag marks the final beat of a burst of fixed length.

Two wrap orders are supported. The sequential order counts upward inside the aligned block that the burst length covers. The interleaved order XORs the beat index into the low bits. A full-page length runs through all columns of the row, wrapping from the top column to zero, and continues until a stop request ends it. Full page is only legal with the sequential order. If it is requested together with the interleaved order, the burst runs as eight interleaved beats and an illegal-configuration flag is raised while it runs.

A new start may arrive on any cycle, including during a burst, because a new column can be accepted every clock.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is held, and in the first cycle after it, beatValid, lastBeat and cfgIllegal are 0 and colOut is 0.
- R2: When startPulse is 1 at a rising edge, beatValid is 1 in the next cycle, and colOut equals the sampled startCol in that cycle. One beat follows per cycle after that.
- R3: With typeIlv=0, lenCode values 0, 1, 2 and 3 select lengths L = 1, 2, 4 and 8. For beat n, the bits of colOut above log2(L) equal those of startCol, and the low log2(L) bits equal (startCol + n) mod L.
- R4: With typeIlv=1 and lenCode 0 to 3, beat n has colOut = startCol XOR n.
- R5: A burst of length L shows exactly L beats. lastBeat is 1 on beat L-1 only, and beatValid is 0 in the cycle after it unless a new start was sampled.
- R6: lenCode with bit 2 set (values 4 to 7) and typeIlv=0 selects full page. Beat n has colOut = (startCol + n) mod 256, wrapping past 255. lastBeat stays 0 and beats continue until stopped.
- R7: When stopReq is 1 at a rising edge and startPulse is 0, beatValid is 0 in the next cycle.
- R8: A start sampled during a burst restarts the sequence at the next beat with the new column and configuration. A start wins over a stopReq sampled at the same edge.
- R9: lenCode with bit 2 set together with typeIlv=1 is illegal. The burst runs as an interleaved burst of 8 beats, and cfgIllegal is 1 on each of its beats.
- R10: In any cycle with beatValid 0, colOut is 0.
- R11: lenCode and typeIlv are sampled only with startPulse. Changing them during a burst has no effect on its addresses or length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| startPulse | input | 1 | Starts a burst at this edge |
| startCol | input | 8 | Column supplied with the command |
| lenCode | input | 3 | Burst length: 0..3 give 1/2/4/8, bit 2 set gives full page |
| typeIlv | input | 1 | 0 sequential order, 1 interleaved order |
| stopReq | input | 1 | Burst stop / interrupt |
| colOut | output | 8 | Column of the current beat, 0 when idle |
| beatValid | output | 1 | A beat is presented this cycle |
| lastBeat | output | 1 | Current beat is the final one of a fixed-length burst |
| cfgIllegal | output | 1 | Current burst uses interleave with full page |

## Verification
Several properties are checked on every cycle. They cover the first beat after a start, which carries the sampled start column, and the idle column of zero. They also cover the ending of a burst after its last beat or after a stop, and the constraint that lastBeat and cfgIllegal never appear without a valid beat. The bench scenarios are needed to show the actual wrap orders beat by beat. It sweeps every start column with each fixed length and both orders, and runs a full page past the 255-to-0 wrap. It also covers restart during a burst, the illegal combination, and the fact that mode inputs are ignored mid-burst.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  parameter int COL_W = 8;
  parameter int LEN_W = 3;

  typedef logic [COL_W-1:0] col_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // capture start column, clear offset
    logic step;    // advance offset by one beat
    logic useIlv;  // interleaved wrap order
    col_t mask;    // bits that wrap within the burst
  } ctrlStrobes_t;
endpackage

// File: rtl/bcg_ctrl.sv
module bcg_ctrl
  import bcg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic [LEN_W-1:0] lenCode,
  input  logic             typeIlv,
  input  logic             stopReq,
  input  col_t             offset,
  output ctrlStrobes_t     strobes,
  output logic             activeOut,
  output logic             lastOut,
  output logic             illegalOut
);
  localparam col_t FULL_MASK = '1;
  localparam col_t ILV_FULL_MASK = col_t'(7);

  logic activeQ, ilvQ, fullQ, illegalQ;
  col_t maskQ;
  col_t newMask;
  logic newFull, newIllegal, lastNow;

  always_comb begin
    newFull    = lenCode[LEN_W-1] && !typeIlv;
    newIllegal = lenCode[LEN_W-1] && typeIlv;
    if (newFull)
      newMask = FULL_MASK;
    else if (newIllegal)
      newMask = ILV_FULL_MASK;
    else
      newMask = col_t'((1 << lenCode[1:0]) - 1);
  end

  assign lastNow = activeQ && !fullQ && (offset == maskQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeQ  <= 1'b0;
      ilvQ     <= 1'b0;
      fullQ    <= 1'b0;
      illegalQ <= 1'b0;
      maskQ    <= '0;
    end else if (startPulse) begin
      activeQ  <= 1'b1;
      ilvQ     <= typeIlv;
      fullQ    <= newFull;
      illegalQ <= newIllegal;
      maskQ    <= newMask;
    end else if (stopReq || lastNow) begin
      activeQ  <= 1'b0;
    end
  end

  assign strobes.load   = startPulse;
  assign strobes.step   = activeQ && !startPulse;
  assign strobes.useIlv = ilvQ;
  assign strobes.mask   = maskQ;

  assign activeOut  = activeQ;
  assign lastOut    = lastNow;
  assign illegalOut = activeQ && illegalQ;
endmodule

// File: rtl/bcg_dp.sv
module bcg_dp
  import bcg_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strobes,
  input  col_t         startCol,
  input  logic         beatOn,
  output col_t         offset,
  output col_t         colOut
);
  col_t baseQ, offQ, colNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ <= '0;
      offQ  <= '0;
    end else if (strobes.load) begin
      baseQ <= startCol;
      offQ  <= '0;
    end else if (strobes.step) begin
      offQ  <= offQ + col_t'(1);
    end
  end

  always_comb begin
    if (strobes.useIlv)
      colNow = baseQ ^ offQ;
    else
      colNow = (baseQ & ~strobes.mask) | ((baseQ + offQ) & strobes.mask);
  end

  assign offset = offQ;
  assign colOut = beatOn ? colNow : '0;
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import bcg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic [COL_W-1:0] startCol,
  input  logic [LEN_W-1:0] lenCode,
  input  logic             typeIlv,
  input  logic             stopReq,
  output logic [COL_W-1:0] colOut,
  output logic             beatValid,
  output logic             lastBeat,
  output logic             cfgIllegal
);
  ctrlStrobes_t strobes;
  col_t offset;

  bcg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .lenCode(lenCode),
    .typeIlv(typeIlv), .stopReq(stopReq), .offset(offset),
    .strobes(strobes), .activeOut(beatValid), .lastOut(lastBeat),
    .illegalOut(cfgIllegal)
  );

  bcg_dp u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .startCol(startCol),
    .beatOn(beatValid), .offset(offset), .colOut(colOut)
  );
endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk
  import bcg_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             startPulse,
  input logic [COL_W-1:0] startCol,
  input logic             stopReq,
  input logic [COL_W-1:0] colOut,
  input logic             beatValid,
  input logic             lastBeat,
  input logic             cfgIllegal
);
  a_r2_start_valid: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> beatValid);

  a_r2_first_col: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> (colOut == $past(startCol)));

  a_r5_last_with_valid: assert property (@(posedge clk) disable iff (!rstN)
    lastBeat |-> beatValid);

  a_r5_last_ends: assert property (@(posedge clk) disable iff (!rstN)
    (lastBeat && !startPulse) |=> !beatValid);

  a_r7_stop_ends: assert property (@(posedge clk) disable iff (!rstN)
    (stopReq && !startPulse) |=> !beatValid);

  a_r9_flag_with_valid: assert property (@(posedge clk) disable iff (!rstN)
    cfgIllegal |-> beatValid);

  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !beatValid |-> (colOut == '0));
endmodule

bind burst_col_gen burst_col_gen_chk u_chk (
  .clk(clk), .rstN(rstN), .startPulse(startPulse), .startCol(startCol),
  .stopReq(stopReq), .colOut(colOut), .beatValid(beatValid),
  .lastBeat(lastBeat), .cfgIllegal(cfgIllegal)
);

// File: tb/sim_burst_col_gen.sv
`timescale 1ns/1ps
module sim_burst_col_gen;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startPulse = 1'b0;
  logic [7:0] startCol = '0;
  logic [2:0] lenCode = '0;
  logic typeIlv = 1'b0;
  logic stopReq = 1'b0;
  logic [7:0] colOut;
  logic beatValid, lastBeat, cfgIllegal;

  int vecs = 0;
  int errs = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_col_gen u0 (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .startCol(startCol),
    .lenCode(lenCode), .typeIlv(typeIlv), .stopReq(stopReq),
    .colOut(colOut), .beatValid(beatValid), .lastBeat(lastBeat),
    .cfgIllegal(cfgIllegal)
  );

  task automatic chk(input string req, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] expCol(input logic [7:0] s, input int len,
                                        input bit ilv, input int n);
    logic [7:0] m = 8'(len - 1);
    if (ilv) return s ^ 8'(n);
    return (s & ~m) | (8'(s + 8'(n)) & m);
  endfunction

  // Issue a start at the next edge; returns at the negedge showing beat 0.
  task automatic issue(input logic [7:0] s, input logic [2:0] code,
                       input bit ilv, input bit stp);
    startPulse = 1'b1; startCol = s; lenCode = code; typeIlv = ilv;
    stopReq = stp;
    @(negedge clk);
    startPulse = 1'b0; stopReq = 1'b0;
    lenCode = ~code; typeIlv = ~ilv;   // R11: must be ignored
    startCol = ~s;
  endtask

  // Check L beats of a fixed burst starting at the current negedge.
  task automatic runFixed(input logic [7:0] s, input int len, input bit ilv,
                          input bit illegal, input string tag);
    for (int n = 0; n < len; n++) begin
      chk({tag, " col"}, colOut, expCol(s, len, ilv, n));
      chk("R5 valid", beatValid, 1);
      chk("R5 last", lastBeat, (n == len - 1) ? 1 : 0);
      chk("R9 illegal flag", cfgIllegal, illegal ? 1 : 0);
      @(negedge clk);
    end
    chk("R5 ends", beatValid, 0);
    chk("R10 idle col", colOut, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 valid", beatValid, 0);
    chk("R1 last", lastBeat, 0);
    chk("R1 illegal", cfgIllegal, 0);
    chk("R1 col", colOut, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 valid after release", beatValid, 0);

    // R2 R3 R4 R11 sweep: all start columns, lengths 1..8, both orders
    for (int ilv = 0; ilv < 2; ilv++)
      for (int code = 0; code < 4; code++)
        for (int s = 0; s < 256; s++) begin
          issue(8'(s), 3'(code), bit'(ilv), 1'b0);
          chk("R2 first col", colOut, s);
          runFixed(8'(s), 1 << code, bit'(ilv), 1'b0, ilv ? "R4" : "R3");
        end

    // R6 full page, wrap past 255, then R7 stop
    for (int code = 4; code < 8; code++) begin
      issue(8'hFA - 8'(code), 3'(code), 1'b0, 1'b0);
      for (int n = 0; n < 300; n++) begin
        chk("R6 col", colOut, 8'(8'hFA - 8'(code) + 8'(n)));
        chk("R6 no last", lastBeat, 0);
        chk("R6 valid", beatValid, 1);
        if (n == 299) stopReq = 1'b1;
        @(negedge clk);
      end
      stopReq = 1'b0;
      chk("R7 stopped", beatValid, 0);
    end

    // R7 stop in the middle of an 8-beat burst
    issue(8'h44, 3'd3, 1'b0, 1'b0);
    @(negedge clk); @(negedge clk);
    chk("R7 col before stop", colOut, 8'h46);
    stopReq = 1'b1;
    @(negedge clk);
    stopReq = 1'b0;
    chk("R7 stop mid burst", beatValid, 0);

    // R9 illegal interleave + full page behaves as 8 interleaved beats
    issue(8'h35, 3'd7, 1'b1, 1'b0);
    runFixed(8'h35, 8, 1'b1, 1'b1, "R9");
    issue(8'hC2, 3'd5, 1'b1, 1'b0);
    runFixed(8'hC2, 8, 1'b1, 1'b1, "R9");

    // R8 restart mid burst; start beats simultaneous stop
    issue(8'h10, 3'd3, 1'b0, 1'b0);
    @(negedge clk); @(negedge clk);
    chk("R8 before restart", colOut, 8'h12);
    issue(8'h83, 3'd2, 1'b1, 1'b1);
    runFixed(8'h83, 4, 1'b1, 1'b0, "R8");

    // R8 back-to-back starts every cycle
    for (int k = 0; k < 6; k++) begin
      issue(8'(8'h20 + 8'(k * 9)), 3'd3, 1'b0, 1'b0);
      chk("R8 back-to-back col", colOut, 8'h20 + 8'(k * 9));
    end
    runFixed(8'h20 + 8'd45, 8, 1'b0, 1'b0, "R8");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule